// File: doc/BRIEF.md
# Secure Mode Trap and Cause Register

This block holds the privilege state of a processor subsystem and records why the processor was last forced into secure mode. A single 32-bit register carries the secure-mode flag, the boot-window swap flag, an enable that opens a small secure RAM to non-secure code, and six trap-cause flags. Any trap event forces the processor back into secure mode and produces a one-cycle non-maskable interrupt request. The processor's exception logic sends that request to a fixed vector.

Non-secure code has a call gate into secure code. It reads the register, and that read is itself a trap source, recorded as an application request. Once secure code clears the secure flag, privilege is gone: software cannot set the flag again, and only a trap restores it.

The block also decodes accesses to a boot window. The window holds a boot ROM slot and a secure RAM slot, whose order is set by the swap flag, plus a 32 KiB auxiliary secure RAM. The block grants or refuses each access according to the current privilege. The actual memories are outside the block.

Top module: `secx_trap_ctrl`

## Requirements
- R1: After reset the register reads 0x00000003: bit 0 (secure) and bit 1 (swap) are set, all other bits are clear, and `nmi_o` is low.
- R2: A register write while secure loads bits 0, 1, 7:2 and 24 from the write data. Every other bit always reads 0. Writing 0 to bit 0 drops `secure_o` from the next cycle on.
- R3: A register write while not secure has no effect on any bit. This includes attempts to set bit 0, bit 1 or bit 24.
- R4: A pulse on `hw_evt_i[k]` sets cause bit k+3 and forces bit 0 to 1. It raises `nmi_o` for exactly one cycle, and all three happen at the same clock edge. The event mapping is: k=0 secure timer, k=1 peripheral bus error, k=2 memory interface error, k=3 power button, k=4 card removal.
- R5: A register read while not secure returns the current contents. At the same edge it sets bit 2 (application request), sets bit 0, and pulses `nmi_o`.
- R6: A register read while secure causes no trap.
- R7: With bit 1 set, window offsets 0x00000-0x1FFFF select the boot ROM and offsets 0x20000-0x3FFFF select the secure RAM. With bit 1 clear, the two are swapped.
- R8: Offsets 0x40000-0x47FFF select the 32 KiB auxiliary RAM. Secure code may always access it. Non-secure code may access it only when bit 24 is set. Offsets from 0x48000 up select nothing and raise no violation.
- R9: A non-secure access to the boot ROM or secure RAM, or to the auxiliary RAM with bit 24 clear, returns zero data, asserts `viol_o` and asserts no select. A permitted access passes `mem_rdata_i` through.
- R10: When a trap and a secure write fall on the same edge, the trap cause bits are merged into the written value and bit 0 ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (zero when no read) |
| hw_evt_i | input | 5 | Hardware trap event pulses (mapping in R4) |
| nmi_o | output | 1 | One-cycle non-maskable trap request |
| secure_o | output | 1 | Current secure-mode state |
| mem_valid_i | input | 1 | Boot-window access valid |
| mem_addr_i | input | 19 | Offset within the boot window |
| mem_rdata_i | input | 32 | Read data from the selected memory |
| mem_rdata_o | output | 32 | Read data gated by permission |
| mem_loc_o | output | 17 | Offset within the selected slot |
| rom_sel_o | output | 1 | Permitted boot ROM access |
| sram_sel_o | output | 1 | Permitted secure RAM access |
| xram_sel_o | output | 1 | Permitted auxiliary RAM access |
| viol_o | output | 1 | Refused access |

## Verification
On every cycle, the assertions check the following: a trap is followed by a set secure flag and an NMI pulse, and every NMI comes with a recorded cause. A non-secure write leaves the register unchanged, and secure mode is only ever entered again through a trap. Reserved bits stay zero. A refused access returns zero data and happens only outside secure mode. The bench scenarios are needed for the actual bit values: how each event maps to its cause bit, which memory the swap flag selects, the 32 KiB bound of the auxiliary RAM, and the merged value of a write that falls on the same edge as a trap.

// File: rtl/secx_pkg.sv
package secx_pkg;
   localparam int CAUSE_W  = 32;
   localparam int BIT_SEC  = 0;
   localparam int BIT_SWAP = 1;
   localparam int BIT_APP  = 2;
   localparam int BIT_HW0  = 3;
   localparam int N_HW     = 5;
   localparam int BIT_XEN  = 24;
   localparam logic [CAUSE_W-1:0] WR_MASK =
      (CAUSE_W'(1) << BIT_XEN) | ((CAUSE_W'(1) << (BIT_HW0 + N_HW)) - CAUSE_W'(1));
   localparam logic [CAUSE_W-1:0] RST_VAL =
      (CAUSE_W'(1) << BIT_SEC) | (CAUSE_W'(1) << BIT_SWAP);

   typedef enum logic [1:0] {
      SLOT_LOW  = 2'd0,
      SLOT_HIGH = 2'd1,
      SLOT_AUX  = 2'd2,
      SLOT_NONE = 2'd3
   } slot_e;
endpackage

// File: rtl/secx_cause_reg.sv
module secx_cause_reg
   import secx_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic               rd_en_i,
   input  logic [CAUSE_W-1:0] wdata_i,
   input  logic [N_HW-1:0]    hw_evt_i,
   output logic [CAUSE_W-1:0] cause_o,
   output logic               nmi_o
);
   localparam int TRAP_W = N_HW + 1;

   if (BIT_APP + TRAP_W > BIT_XEN) begin : g_bad_layout
      $error("cause field overlaps the auxiliary enable bit");
   end

   logic [CAUSE_W-1:0] cause_q, cause_d;
   logic [TRAP_W-1:0]  trap_vec;
   logic               trap_any;
   logic               nmi_q;

   assign trap_vec[0] = rd_en_i & ~cause_q[BIT_SEC];
   for (genvar i = 0; i < N_HW; i++) begin : g_evt
      assign trap_vec[i+1] = hw_evt_i[i];
   end
   assign trap_any = |trap_vec;

   always_comb begin
      cause_d = cause_q;
      if (wr_en_i && cause_q[BIT_SEC]) begin
         cause_d = wdata_i & WR_MASK;
      end
      cause_d[BIT_APP +: TRAP_W] = cause_d[BIT_APP +: TRAP_W] | trap_vec;
      if (trap_any) begin
         cause_d[BIT_SEC] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cause_q <= RST_VAL;
         nmi_q   <= 1'b0;
      end else begin
         cause_q <= cause_d;
         nmi_q   <= trap_any;
      end
   end

   assign cause_o = cause_q;
   assign nmi_o   = nmi_q;

   a_r4_trap_gives_nmi: assert property (@(posedge clk) disable iff (!rst_n)
      trap_any |=> (nmi_q && cause_q[BIT_SEC]));
   a_r4_nmi_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_q |-> (|cause_q[BIT_APP +: TRAP_W]));
   a_r3_nonsecure_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !cause_q[BIT_SEC] && !trap_any) |=> $stable(cause_q));
   a_r2_reentry_only_by_trap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cause_q[BIT_SEC]) |-> nmi_q);
   a_r5_app_read_traps: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !cause_q[BIT_SEC]) |=> (cause_q[BIT_APP] && nmi_q));
   a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_q & ~WR_MASK) == '0);
endmodule

// File: rtl/secx_window_dec.sv
module secx_window_dec
   import secx_pkg::*;
#(
   parameter int WIN_AW  = 19,
   parameter int SLOT_AW = 17,
   parameter int XRAM_AW = 15,
   parameter int MDATA_W = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               secure_i,
   input  logic               swap_i,
   input  logic               xen_i,
   input  logic               valid_i,
   input  logic [WIN_AW-1:0]  addr_i,
   input  logic [MDATA_W-1:0] rdata_i,
   output logic [MDATA_W-1:0] rdata_o,
   output logic [SLOT_AW-1:0] loc_o,
   output logic               rom_sel_o,
   output logic               sram_sel_o,
   output logic               xram_sel_o,
   output logic               viol_o
);
   if (WIN_AW != SLOT_AW + 2) begin : g_bad_win
      $error("window must hold exactly four slots");
   end
   if (XRAM_AW > SLOT_AW) begin : g_bad_xram
      $error("auxiliary RAM larger than a slot");
   end

   slot_e slot;
   logic  xram_in;
   logic  hit_rom, hit_sram, hit_x;
   logic  main_ok, x_ok, grant;

   assign slot  = slot_e'(addr_i[WIN_AW-1 -: 2]);
   assign loc_o = addr_i[SLOT_AW-1:0];

   if (XRAM_AW < SLOT_AW) begin : g_xram_part
      assign xram_in = ~|addr_i[SLOT_AW-1:XRAM_AW];
   end else begin : g_xram_full
      assign xram_in = 1'b1;
   end

   assign hit_rom  = (slot == SLOT_LOW  &&  swap_i) || (slot == SLOT_HIGH && !swap_i);
   assign hit_sram = (slot == SLOT_LOW  && !swap_i) || (slot == SLOT_HIGH &&  swap_i);
   assign hit_x    = (slot == SLOT_AUX) && xram_in;

   assign main_ok = secure_i;
   assign x_ok    = secure_i | xen_i;

   assign rom_sel_o  = valid_i & hit_rom  & main_ok;
   assign sram_sel_o = valid_i & hit_sram & main_ok;
   assign xram_sel_o = valid_i & hit_x    & x_ok;
   assign grant      = rom_sel_o | sram_sel_o | xram_sel_o;
   assign viol_o     = valid_i & (((hit_rom | hit_sram) & ~main_ok) | (hit_x & ~x_ok));
   assign rdata_o    = grant ? rdata_i : '0;

   a_r9_viol_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> (rdata_o == '0));
   a_r9_viol_only_nonsecure: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> !secure_i);
   a_r7_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_sel_o, sram_sel_o, xram_sel_o, viol_o}));
endmodule

// File: rtl/secx_trap_ctrl.sv
module secx_trap_ctrl
   import secx_pkg::*;
#(
   parameter int WIN_AW  = 19,
   parameter int SLOT_AW = 17,
   parameter int XRAM_AW = 15,
   parameter int MDATA_W = 32
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_rd_i,
   input  logic               reg_wr_i,
   input  logic [31:0]        reg_wdata_i,
   output logic [31:0]        reg_rdata_o,
   input  logic [4:0]         hw_evt_i,
   output logic               nmi_o,
   output logic               secure_o,
   input  logic               mem_valid_i,
   input  logic [WIN_AW-1:0]  mem_addr_i,
   input  logic [MDATA_W-1:0] mem_rdata_i,
   output logic [MDATA_W-1:0] mem_rdata_o,
   output logic [SLOT_AW-1:0] mem_loc_o,
   output logic               rom_sel_o,
   output logic               sram_sel_o,
   output logic               xram_sel_o,
   output logic               viol_o
);
   if (CAUSE_W != 32 || N_HW != 5) begin : g_bad_pkg
      $error("register layout does not match the port widths");
   end

   logic [CAUSE_W-1:0] cause;

   secx_cause_reg u_cause (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (reg_wr_i),
      .rd_en_i  (reg_rd_i),
      .wdata_i  (reg_wdata_i),
      .hw_evt_i (hw_evt_i),
      .cause_o  (cause),
      .nmi_o    (nmi_o)
   );

   secx_window_dec #(
      .WIN_AW  (WIN_AW),
      .SLOT_AW (SLOT_AW),
      .XRAM_AW (XRAM_AW),
      .MDATA_W (MDATA_W)
   ) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .secure_i   (cause[BIT_SEC]),
      .swap_i     (cause[BIT_SWAP]),
      .xen_i      (cause[BIT_XEN]),
      .valid_i    (mem_valid_i),
      .addr_i     (mem_addr_i),
      .rdata_i    (mem_rdata_i),
      .rdata_o    (mem_rdata_o),
      .loc_o      (mem_loc_o),
      .rom_sel_o  (rom_sel_o),
      .sram_sel_o (sram_sel_o),
      .xram_sel_o (xram_sel_o),
      .viol_o     (viol_o)
   );

   assign secure_o    = cause[BIT_SEC];
   assign reg_rdata_o = reg_rd_i ? cause : '0;
endmodule

// File: tb/secx_trap_ctrl_tb_top.sv
module secx_trap_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_rd = 1'b0, reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [4:0]  hw_evt = '0;
   logic        nmi, secure;
   logic        mem_valid = 1'b0;
   logic [18:0] mem_addr = '0;
   logic [31:0] mem_rdata_in, mem_rdata_out;
   logic [16:0] mem_loc;
   logic        rom_sel, sram_sel, xram_sel, viol;
   int          checks = 0, failures = 0;

   always #2 clk = ~clk;
   assign mem_rdata_in = 32'hA5A5_0000 ^ {13'd0, mem_addr};

   secx_trap_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_rd_i(reg_rd), .reg_wr_i(reg_wr),
      .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .hw_evt_i(hw_evt),
      .nmi_o(nmi), .secure_o(secure), .mem_valid_i(mem_valid),
      .mem_addr_i(mem_addr), .mem_rdata_i(mem_rdata_in), .mem_rdata_o(mem_rdata_out),
      .mem_loc_o(mem_loc), .rom_sel_o(rom_sel), .sram_sel_o(sram_sel),
      .xram_sel_o(xram_sel), .viol_o(viol)
   );

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic reg_read(output logic [31:0] v);
      @(negedge clk); reg_rd = 1'b1; #1 v = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic pulse_evt(logic [4:0] e);
      @(negedge clk); hw_evt = e;
      @(negedge clk); hw_evt = '0;
   endtask

   // expected {rom,sram,xram,viol} and data
   task automatic probe(string req, logic [18:0] a, logic [3:0] exp_sel, logic pass);
      @(negedge clk); mem_valid = 1'b1; mem_addr = a; #1;
      check(req, "select/viol", {28'd0, rom_sel, sram_sel, xram_sel, viol}, {28'd0, exp_sel});
      check(req, "mem data", mem_rdata_out, pass ? (32'hA5A5_0000 ^ {13'd0, a}) : 32'd0);
      mem_valid = 1'b0;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      check("R1", "nmi at reset", {31'd0, nmi}, 32'd0);
      check("R1", "secure at reset", {31'd0, secure}, 32'd1);
      reg_read(v);
      check("R1", "reset value", v, 32'h0000_0003);
      check("R6", "no nmi on secure read", {31'd0, nmi}, 32'd0);
   endtask

   task automatic t_decode;
      probe("R7", 19'h00010, 4'b1000, 1'b1);
      probe("R7", 19'h20010, 4'b0100, 1'b1);
      reg_write(32'h0000_0001);
      probe("R7", 19'h00010, 4'b0100, 1'b1);
      probe("R7", 19'h20010, 4'b1000, 1'b1);
      probe("R8", 19'h40010, 4'b0010, 1'b1);
      probe("R8", 19'h48000, 4'b0000, 1'b0);
      probe("R8", 19'h60000, 4'b0000, 1'b0);
      reg_write(32'h0000_0003);
   endtask

   task automatic t_fields;
      logic [31:0] v;
      reg_write(32'hFFFF_FFFD);
      reg_read(v);
      check("R2", "writable fields", v, 32'h0100_00FD);
      reg_write(32'h0000_0003);
      reg_read(v);
      check("R2", "fields cleared", v, 32'h0000_0003);
   endtask

   task automatic t_exit_and_ignore;
      logic [31:0] v;
      reg_write(32'h0000_0002);
      check("R2", "secure dropped", {31'd0, secure}, 32'd0);
      probe("R9", 19'h00010, 4'b0001, 1'b0);
      probe("R9", 19'h20010, 4'b0001, 1'b0);
      probe("R9", 19'h40010, 4'b0001, 1'b0);
      reg_write(32'h0100_0001);
      check("R3", "nonsecure cannot re-enter", {31'd0, secure}, 32'd0);
      check("R3", "no nmi from write", {31'd0, nmi}, 32'd0);
      probe("R3", 19'h40010, 4'b0001, 1'b0);
      reg_write(32'h0000_0000);
      reg_read(v);
      check("R5", "nonsecure read data", v, 32'h0000_0002);
      check("R5", "nmi after app read", {31'd0, nmi}, 32'd1);
      check("R5", "secure after app read", {31'd0, secure}, 32'd1);
      @(negedge clk);
      check("R4", "nmi is one cycle", {31'd0, nmi}, 32'd0);
      reg_read(v);
      check("R3", "swap kept, app cause set (R5)", v, 32'h0000_0007);
      reg_write(32'h0000_0003);
   endtask

   task automatic t_aux_grant;
      logic [31:0] v;
      reg_write(32'h0100_0002);
      check("R8", "secure dropped with grant", {31'd0, secure}, 32'd0);
      probe("R8", 19'h40010, 4'b0010, 1'b1);
      probe("R8", 19'h47FFC, 4'b0010, 1'b1);
      probe("R8", 19'h48000, 4'b0000, 1'b0);
      probe("R9", 19'h00010, 4'b0001, 1'b0);
      pulse_evt(5'b00001);
      check("R4", "nmi on timer", {31'd0, nmi}, 32'd1);
      check("R4", "secure on timer", {31'd0, secure}, 32'd1);
      reg_read(v);
      check("R4", "timer cause", v, 32'h0100_000B);
      reg_write(32'h0000_0003);
   endtask

   task automatic t_event_map;
      logic [31:0] v;
      for (int i = 0; i < 5; i++) begin
         pulse_evt(5'(1 << i));
         check("R4", "nmi per event", {31'd0, nmi}, 32'd1);
         reg_read(v);
         check("R4", "event cause bit", v, 32'h0000_0003 | (32'h8 << i));
         reg_write(32'h0000_0003);
      end
   endtask

   task automatic t_collision;
      logic [31:0] v;
      @(negedge clk); reg_wr = 1'b1; reg_wdata = 32'h0000_0002; hw_evt = 5'b00010;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = '0; hw_evt = '0;
      check("R10", "nmi on collision", {31'd0, nmi}, 32'd1);
      check("R10", "secure kept", {31'd0, secure}, 32'd1);
      reg_read(v);
      check("R10", "merged value", v, 32'h0000_0013);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_decode();
      t_fields();
      t_exit_and_ignore();
      t_aux_grant();
      t_event_map();
      t_collision();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule